// File: doc/BRIEF.md
# Trigger Veto and Delayed Stop Generator

This block sits in a trigger distribution path and runs on a 20 ns clock. It takes a global trigger that is asynchronous to the clock, brings it into the clock domain and detects its rising edge. If no veto is active at that moment, it accepts the trigger. On acceptance it raises a one-cycle acknowledge flag and starts an immediate stop pulse. It also schedules a second, delayed common-stop pulse.

A single 10-bit setting N controls two timings. It gives the length of the counter-busy veto, which lasts N clock periods. It also gives the delay of the second pulse, which starts N − 47 periods after the first. A 4-bit setting gives the width of both pulses in clock periods. All settings are captured at the moment a trigger is accepted.

The block has three external veto sources: a detector-busy veto, a remote register veto and an active-low test veto. These are ORed with the counter-busy veto into one veto status output. The test veto also cuts off pulse generation that is already in progress.

Top module: `trig_veto_gen`

## Requirements
- R1: While `rst_n` is low, `stop_pulse`, `delayed_stop` and `trig_ok` are low. With every external veto inactive, `veto_status` is also low.
- R2: `trig_in` passes through a two-stage synchroniser and an edge detector. Acceptance happens on the third rising clock edge at which `trig_in` has been high, so `trig_ok` is high for the clock period after that edge. A trigger held high for many cycles is accepted at most once.
- R3: On acceptance, `stop_pulse` goes high in the same period as `trig_ok` and stays high for W periods, where W is `width_set`. When W = 0 there is no pulse.
- R4: On acceptance, the counter-busy veto holds `veto_status` high for exactly N periods, starting with the `trig_ok` period. N is the value of `delay_set`, with bit 0 as the least significant bit.
- R5: When 50 ≤ N ≤ 1022, `delayed_stop` goes high N − 47 periods after `stop_pulse` went high and stays high for W periods.
- R6: When N < 50, no delayed pulse is produced.
- R7: When N = 0 or N = 1023, a trigger produces no `trig_ok`, no pulse and no busy period.
- R8: A trigger edge is ignored while `veto_status` is high in the period before the acceptance edge. This covers counter-busy, `bip_veto` and `remote_veto`.
- R9: `veto_status` is the OR of the counter-busy veto, `bip_veto` high, `remote_veto` high and `test_veto_n` low.
- R10: A clock edge that samples `test_veto_n` low ends any running pulse on both outputs from the next period on. It also cancels a delayed pulse that has not yet started. Neither canceled pulse resumes.
- R11: N and W are captured at acceptance. Changing `delay_set` or `width_set` afterwards does not alter the pulses or the busy period of that trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Global trigger, asynchronous |
| delay_set | input | 10 | Busy length N; delayed pulse follows at N − 47 |
| width_set | input | 4 | Pulse width in clock periods |
| bip_veto | input | 1 | Detector-busy veto, active high |
| remote_veto | input | 1 | Remote register veto, active high |
| test_veto_n | input | 1 | Test veto, active low |
| stop_pulse | output | 1 | Immediate stop pulse |
| delayed_stop | output | 1 | Delayed common-stop pulse |
| veto_status | output | 1 | Combined veto |
| trig_ok | output | 1 | One-period flag for each accepted trigger |

## Verification
Some relations hold on every cycle and the in-RTL assertions check them there:
- the acknowledge flag never lasts two periods;
- a stop pulse only rises together with an acknowledge;
- an acknowledge always comes with the busy veto;
- no acknowledge follows an invalid setting or an external veto;
- a sampled test veto leaves both pulses low.

Other behaviour depends on the exact count of cycles, and only the bench's cycle-by-cycle reference model can show it. This includes the N-period busy length, the N − 47 delay, the suppression below N = 50, the three-edge acceptance latency and the capture of the settings at acceptance.

// File: rtl/trig_veto_gen.sv
module trig_veto_gen #(
  parameter int SET_W       = 10,
  parameter int PW_W        = 4,
  parameter int STOP_LAG    = 47,
  parameter int MIN_LAG_SET = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic [SET_W-1:0] delay_set,
  input  logic [PW_W-1:0]  width_set,
  input  logic             bip_veto,
  input  logic             remote_veto,
  input  logic             test_veto_n,
  output logic             stop_pulse,
  output logic             delayed_stop,
  output logic             veto_status,
  output logic             trig_ok
);
  localparam logic [SET_W-1:0] SET_ALL1 = '1;
  localparam logic [SET_W-1:0] LAG_OFS  = SET_W'(STOP_LAG);
  localparam logic [SET_W-1:0] LAG_MIN  = SET_W'(MIN_LAG_SET);
  localparam logic [SET_W-1:0] ONE_SET  = SET_W'(1);

  logic [2:0]       trig_sync;
  logic [SET_W-1:0] busy_cnt, lag_cnt, lag_load;
  logic [PW_W-1:0]  stop_cnt, dly_cnt, width_hold;
  logic             setting_ok, edge_seen, accept, test_veto;

  assign test_veto    = ~test_veto_n;
  assign setting_ok   = (delay_set != '0) && (delay_set != SET_ALL1);
  assign edge_seen    = trig_sync[1] & ~trig_sync[2];
  assign veto_status  = (busy_cnt != '0) | bip_veto | remote_veto | test_veto;
  assign accept       = edge_seen & ~veto_status & setting_ok;
  assign lag_load     = (delay_set >= LAG_MIN) ? delay_set - LAG_OFS : '0;
  assign stop_pulse   = stop_cnt != '0;
  assign delayed_stop = dly_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_sync  <= '0;
      trig_ok    <= 1'b0;
      busy_cnt   <= '0;
      lag_cnt    <= '0;
      stop_cnt   <= '0;
      dly_cnt    <= '0;
      width_hold <= '0;
    end else begin
      trig_sync <= {trig_sync[1:0], trig_in};
      trig_ok   <= accept;

      if (accept)               busy_cnt <= delay_set;
      else if (busy_cnt != '0)  busy_cnt <= busy_cnt - 1'b1;

      if (accept) width_hold <= width_set;

      if (test_veto)            stop_cnt <= '0;
      else if (accept)          stop_cnt <= width_set;
      else if (stop_cnt != '0)  stop_cnt <= stop_cnt - 1'b1;

      if (test_veto)            lag_cnt <= '0;
      else if (accept)          lag_cnt <= lag_load;
      else if (lag_cnt != '0)   lag_cnt <= lag_cnt - 1'b1;

      if (test_veto)            dly_cnt <= '0;
      else if (lag_cnt == ONE_SET) dly_cnt <= width_hold;
      else if (dly_cnt != '0)   dly_cnt <= dly_cnt - 1'b1;
    end
  end

  assert_okone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ok |=> !trig_ok);

  assert_stopok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_pulse) |-> trig_ok);

  assert_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ok |-> veto_status);

  assert_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ok |-> $past(delay_set != '0 && delay_set != SET_ALL1));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ok |-> $past(!bip_veto && !remote_veto && test_veto_n));

  assert_testblk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !test_veto_n |=> (!stop_pulse && !delayed_stop));
endmodule

// File: tb/trig_veto_gen_tb.sv
`timescale 1ns/100ps
module trig_veto_gen_tb;
  logic clk = 0, rst_n = 0, trig_in = 0;
  logic [9:0] delay_set = 10'd97;
  logic [3:0] width_set = 4'd15;
  logic bip_veto = 0, remote_veto = 0, test_veto_n = 1;
  logic stop_pulse, delayed_stop, veto_status, trig_ok;

  trig_veto_gen u_dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .delay_set(delay_set),
    .width_set(width_set), .bip_veto(bip_veto), .remote_veto(remote_veto),
    .test_veto_n(test_veto_n), .stop_pulse(stop_pulse), .delayed_stop(delayed_stop),
    .veto_status(veto_status), .trig_ok(trig_ok));

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int pend = -1, busy_end = 0, s_beg = 0, s_end = 0, d_beg = 0, d_end = 0, ok_at = -1;
  bit prev_trig = 0, done = 0;

  // behavioural reference: event times in clock periods
  always @(posedge clk) begin
    int n, w;
    bit veto_prev;
    cyc++;
    if (!rst_n) begin
      prev_trig = 0; pend = -1; busy_end = 0; ok_at = -1;
      s_beg = 0; s_end = 0; d_beg = 0; d_end = 0;
    end else begin
      n = delay_set; w = width_set;
      veto_prev = (cyc - 1 < busy_end) || bip_veto || remote_veto || !test_veto_n;
      if (pend == cyc && !veto_prev && n != 0 && n != 1023) begin
        ok_at = cyc; busy_end = cyc + n; s_beg = cyc; s_end = cyc + w;
        if (n >= 50) begin d_beg = cyc + n - 47; d_end = d_beg + w; end
        else begin d_beg = 0; d_end = 0; end
      end
      if (!test_veto_n) begin
        if (s_end > cyc) s_end = cyc;
        if (d_end > cyc) d_end = cyc;
      end
      if (trig_in && !prev_trig) pend = cyc + 2;
      prev_trig = trig_in;
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got=%0b expected=%0b", tag, cyc, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 stop_pulse", stop_pulse, s_beg <= cyc && cyc < s_end);
    chk("R5 delayed_stop", delayed_stop, d_beg <= cyc && cyc < d_end);
    chk("R9 veto_status", veto_status,
        (cyc < busy_end) || bip_veto || remote_veto || !test_veto_n);
    chk("R2 trig_ok", trig_ok, cyc == ok_at);
  end

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic fire(input int hold);
    trig_in = 1; step(hold); trig_in = 0;
  endtask

  initial begin
    step(3);
    @(negedge clk);
    chk("R1 reset stop", stop_pulse, 0);
    chk("R1 reset delayed", delayed_stop, 0);
    chk("R1 reset ok", trig_ok, 0);
    chk("R1 reset veto", veto_status, 0);
    step(1); rst_n = 1; step(3);

    // R3 R4 R5: nominal delay 50 periods, full width
    delay_set = 97; width_set = 15; fire(3); step(110);
    // R5: minimum delay, narrow pulse
    delay_set = 50; width_set = 3; fire(2); step(60);
    // R6: no delayed pulse below 50
    delay_set = 49; width_set = 5; fire(2); step(60);
    // R7: invalid settings
    delay_set = 0; fire(3); step(10);
    delay_set = 10'h3FF; fire(3); step(10);
    // R3: zero width
    delay_set = 60; width_set = 0; fire(2); step(70);
    // R2: long trigger accepted once
    delay_set = 5; width_set = 2; fire(40); step(10);
    // R8: retrigger during busy ignored
    delay_set = 200; width_set = 4; fire(2); step(50); fire(2); step(160);
    // R8 R9: external vetoes block acceptance
    bip_veto = 1; step(2); fire(3); step(3); bip_veto = 0; step(3);
    remote_veto = 1; step(2); fire(3); step(3); remote_veto = 0; step(3);
    test_veto_n = 0; step(2); fire(3); step(3); test_veto_n = 1; step(3);
    // R10: cancel a pending delayed pulse and truncate a running one
    delay_set = 100; width_set = 15; fire(2); step(6);
    test_veto_n = 0; step(1); test_veto_n = 1; step(120);
    delay_set = 80; width_set = 10; fire(2); step(37);
    test_veto_n = 0; step(2); test_veto_n = 1; step(60);
    // R11: settings changed right after acceptance
    delay_set = 70; width_set = 6; fire(2); step(2);
    delay_set = 300; width_set = 1; step(80);
    // R4: short busy then quick retrigger accepted
    delay_set = 1; width_set = 15; fire(2); step(4); fire(2); step(30);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired at cycle %0d: got=running expected=finished", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule